// File: doc/BRIEF.md
# Reset-Triggered Serial Register Loader

This block brings a small imaging timing chain to a known configuration after every reset. Once the system reset releases, or once a remote restart request is withdrawn, it waits a programmable number of millisecond ticks. It then writes a fixed set of default register words over a three-wire serial bus: first into two analog front-end devices, then into a timing-generator device. Each device has its own active-low load strobe, and there is one shared serial clock and one shared data line.

Every register word is held as up to four bytes. The bytes pass one at a time through an 8-bit shift register and leave most significant bit first. The last byte of a word may carry fewer valid bits than eight. The load strobe is released right after the last valid bit, so the padding bits are never clocked into the target. The timing-generator writes are always wrapped by two writes to its mode register: a write that halts it for programming comes before them, and a write that returns it to execution comes after them.

While the remote restart input is high, the block holds the timing generator in reset and abandons any transfer that is in progress. When the input falls, it runs the whole sequence again from the start. A done flag tells the downstream serial steering logic that the bus has been handed back.

Top module: `regload_seq`

## Requirements
- R1: While `rst_n` is low, `done` is 0, `tg_rst_n` is 0, `sclk` is 0 and all three `load_n` bits are 1.
- R2: After `rst_n` rises, or after `remote_rst` falls, no `load_n` bit goes low for at least DELAY_MS×CLKS_PER_MS clock cycles. The first frame begins no more than 8 cycles after that.
- R3: The frames come in a fixed order: every front-end entry first, device 0 (`load_n[0]`) and then device 1 (`load_n[1]`), in table order, and after them every timing-generator (`load_n[2]`) frame.
- R4: A frame of B bytes whose last byte holds L valid bits gives exactly 8×(B−1)+L rising `sclk` edges while its strobe is low. The bits are the word's most significant bits, sent MSB first, and the strobe rises after the last valid bit.
- R5: While a frame is active, `sclk` rises every 2×SCLK_HALF cycles. `sdata` changes only while `sclk` is low, so it is stable across every rising edge.
- R6: At most one `load_n` bit is low at any time. `sclk` is high only while some strobe is low.
- R7: The first timing-generator frame is the 12-bit program-mode word 0x280. The last one is the 12-bit execution-mode word 0x281. The table entries come between them.
- R8: `done` rises only after the execution-mode frame has ended. It then stays high, and no further frame starts, until the next reset or remote restart.
- R9: Within 4 cycles of `remote_rst` rising, `tg_rst_n` is 0, `done` is 0, `sclk` is 0 and every strobe is 1, even in the middle of a frame. No frame starts while `remote_rst` stays high.
- R10: When `remote_rst` falls, the complete sequence repeats from the first front-end entry, with the same frames as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| remote_rst | input | 1 | Remote restart request, high holds off and aborts loading |
| tg_rst_n | output | 1 | Active-low reset to the timing generator |
| sclk | output | 1 | Serial clock, idle low, data sampled on its rising edge |
| sdata | output | 1 | Serial data, MSB first |
| load_n | output | 3 | Active-low strobes: bit 0 front end 0, bit 1 front end 1, bit 2 timing generator |
| done | output | 1 | High once the whole sequence has completed |

## Verification
A wrong byte index or bit counter inside the serializer shows up as a frame with the wrong bit count or wrong word, and it shows on the strobe edge that ends that frame, a few hundred cycles after release at the latest. A wrong sequencer state shows as frames out of order, a missing mode wrapper, or `done` rising early. A stuck abort path leaves a strobe low or `sclk` high within four cycles of a remote request. The bench decodes every frame at the pins. It sweeps the abort point across the whole sequence and checks that each restart reproduces the power-up frames exactly.

// File: rtl/regload_pkg.sv
package regload_pkg;

  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = 8 * MAX_BYTES;
  localparam int NB_W      = 3;
  localparam int LB_W      = 4;
  localparam int N_FE      = 4;
  localparam int N_TG      = 3;
  localparam int N_DEV     = 3;

  typedef enum logic [1:0] {
    DEV_FE0 = 2'd0,
    DEV_FE1 = 2'd1,
    DEV_TG  = 2'd2
  } dev_e;

  typedef enum logic [1:0] {
    K_FE   = 2'd0,
    K_PROG = 2'd1,
    K_TG   = 2'd2,
    K_EXEC = 2'd3
  } kind_e;

  typedef struct packed {
    dev_e              dev;
    logic [NB_W-1:0]   nbytes;
    logic [LB_W-1:0]   lastbits;
    logic [WORD_W-1:0] word;
  } frame_t;

  // Front-end defaults: write flag, address, test bit and data packed MSB-aligned
  function automatic frame_t fe_default(int idx);
    frame_t f;
    f.nbytes   = NB_W'(2);
    f.lastbits = LB_W'(8);
    f.dev      = (idx < 2) ? DEV_FE0 : DEV_FE1;
    f.word     = (idx % 2 == 0) ? 32'h1C30_0000 : 32'h2250_0000;
    return f;
  endfunction

  // Timing-generator defaults of assorted lengths, exercising padded last bytes
  function automatic frame_t tg_default(int idx);
    frame_t f;
    f.dev = DEV_TG;
    case (idx)
      0:       begin f.nbytes = NB_W'(3); f.lastbits = LB_W'(5); f.word = 32'hA5C3_F000; end
      1:       begin f.nbytes = NB_W'(1); f.lastbits = LB_W'(3); f.word = 32'hE000_0000; end
      default: begin f.nbytes = NB_W'(4); f.lastbits = LB_W'(8); f.word = 32'h1234_5678; end
    endcase
    return f;
  endfunction

  // Mode register write: 12 valid bits, low bit selects execution
  function automatic frame_t tg_mode(logic exec);
    frame_t f;
    f.dev      = DEV_TG;
    f.nbytes   = NB_W'(2);
    f.lastbits = LB_W'(4);
    f.word     = {11'h140, exec, 20'h0};
    return f;
  endfunction

endpackage

// File: rtl/regload_tick.sv
module regload_tick #(
  parameter int CLKS_PER_MS = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(CLKS_PER_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R2: the delay base never outruns its period
  assert_tick_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CLKS_PER_MS - 1));

endmodule

// File: rtl/regload_rom.sv
module regload_rom
  import regload_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  kind_e             kind,
  input  logic [IDX_W-1:0]  idx,
  output frame_t            frm
);
  frame_t fe_tab [N_FE];
  frame_t tg_tab [N_TG];

  for (genvar i = 0; i < N_FE; i++) begin : g_fe
    assign fe_tab[i] = fe_default(i);
  end
  for (genvar j = 0; j < N_TG; j++) begin : g_tg
    assign tg_tab[j] = tg_default(j);
  end

  always_comb begin
    frm = tg_mode(1'b0);
    case (kind)
      K_FE:    if (int'(idx) < N_FE) frm = fe_tab[idx];
      K_TG:    if (int'(idx) < N_TG) frm = tg_tab[idx];
      K_PROG:  frm = tg_mode(1'b0);
      K_EXEC:  frm = tg_mode(1'b1);
      default: frm = tg_mode(1'b0);
    endcase
  end
endmodule

// File: rtl/regload_ser.sv
module regload_ser
  import regload_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  frame_t           frm,
  output logic             busy,
  output logic             frame_done,
  output logic             sclk,
  output logic             sdata,
  output logic [N_DEV-1:0] load_n
);
  localparam int HW  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int GAP = 2 * SCLK_HALF;
  localparam int GW  = $clog2(GAP + 1);

  logic              active, in_gap, sclk_q, done_q;
  logic [HW-1:0]     hcnt;
  logic [GW-1:0]     gcnt;
  logic [7:0]        byte_q;
  logic [3:0]        bit_in_byte;
  logic [NB_W-1:0]   byte_idx, nbytes_q;
  logic [LB_W-1:0]   lastbits_q;
  logic [WORD_W-1:0] word_q;
  logic [N_DEV-1:0]  load_q;
  logic              last_byte;
  logic [3:0]        bits_now;

  function automatic logic [7:0] byte_of(logic [WORD_W-1:0] w, logic [NB_W-1:0] k);
    logic [WORD_W-1:0] t;
    t = w << (8 * int'(k));
    return t[WORD_W-1 -: 8];
  endfunction

  assign last_byte  = (byte_idx == nbytes_q - 1'b1);
  assign bits_now   = last_byte ? lastbits_q : 4'd8;
  assign busy       = active | in_gap;
  assign frame_done = done_q;
  assign sclk       = sclk_q;
  assign sdata      = active & byte_q[7];
  assign load_n     = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; in_gap <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      hcnt <= '0; gcnt <= '0; byte_q <= '0; bit_in_byte <= '0;
      byte_idx <= '0; nbytes_q <= '0; lastbits_q <= '0; word_q <= '0;
      load_q <= '1;
    end else if (abort) begin
      active <= 1'b0; in_gap <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      hcnt <= '0; gcnt <= '0; byte_q <= '0; bit_in_byte <= '0;
      byte_idx <= '0; load_q <= '1;
    end else begin
      done_q <= 1'b0;
      if (active) begin
        if (hcnt == HW'(SCLK_HALF - 1)) begin
          hcnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bit_in_byte == bits_now - 1'b1) begin
              if (last_byte) begin
                active <= 1'b0;
                in_gap <= 1'b1;
                gcnt   <= '0;
                byte_q <= '0;
                load_q <= '1;
              end else begin
                byte_idx    <= byte_idx + 1'b1;
                byte_q      <= byte_of(word_q, byte_idx + 1'b1);
                bit_in_byte <= '0;
              end
            end else begin
              bit_in_byte <= bit_in_byte + 1'b1;
              byte_q      <= {byte_q[6:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end else if (in_gap) begin
        if (gcnt == GW'(GAP - 1)) begin
          in_gap <= 1'b0;
          done_q <= 1'b1;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end else if (start) begin
        active      <= 1'b1;
        word_q      <= frm.word;
        nbytes_q    <= frm.nbytes;
        lastbits_q  <= frm.lastbits;
        byte_idx    <= '0;
        byte_q      <= byte_of(frm.word, '0);
        bit_in_byte <= '0;
        hcnt        <= '0;
        load_q      <= ~(N_DEV'(1) << frm.dev);
      end
    end
  end

  // R5: data holds while the clock is high
  assert_sdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdata));

  // R6: never two strobes at once
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~load_q) <= 1);

  // R6: clock only inside a frame
  assert_sclk_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> (load_q != '1));

  // R4: a strobe rises only on the clock's falling step
  assert_strobe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && $past(!abort) && $past(load_q != '1) && load_q == '1) |-> $past(sclk_q));

endmodule

// File: rtl/regload_seq.sv
module regload_seq
  import regload_pkg::*;
#(
  parameter int CLKS_PER_MS = 80000,
  parameter int DELAY_MS    = 2,
  parameter int SCLK_HALF   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remote_rst,
  output logic             tg_rst_n,
  output logic             sclk,
  output logic             sdata,
  output logic [N_DEV-1:0] load_n,
  output logic             done
);
  localparam int N_MAX = (N_FE > N_TG) ? N_FE : N_TG;
  localparam int IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;
  localparam int MSW   = $clog2(DELAY_MS + 1);

  typedef enum logic [2:0] {
    S_HOLD, S_WAIT, S_FE, S_PROG, S_TG, S_EXEC, S_DONE
  } state_e;

  state_e           state;
  logic             rs1, rs2, tg_rst_q;
  logic [IDX_W-1:0] idx;
  logic [MSW-1:0]   ms_cnt;
  logic             launched, tick, start, ser_busy, frame_done, sending;
  kind_e            kind;
  frame_t           frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0; rs2 <= 1'b0; tg_rst_q <= 1'b0;
    end else begin
      rs1 <= remote_rst; rs2 <= rs1; tg_rst_q <= ~rs2;
    end
  end
  assign tg_rst_n = tg_rst_q;

  regload_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(rs2 || state == S_HOLD), .tick(tick)
  );

  always_comb begin
    case (state)
      S_PROG:  kind = K_PROG;
      S_TG:    kind = K_TG;
      S_EXEC:  kind = K_EXEC;
      default: kind = K_FE;
    endcase
  end

  regload_rom #(.IDX_W(IDX_W)) u_rom (.kind(kind), .idx(idx), .frm(frm));

  assign sending = (state == S_FE) || (state == S_PROG) || (state == S_TG) || (state == S_EXEC);
  assign start   = sending && !launched && !ser_busy && !rs2;

  regload_ser #(.SCLK_HALF(SCLK_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .abort(rs2), .start(start), .frm(frm),
    .busy(ser_busy), .frame_done(frame_done),
    .sclk(sclk), .sdata(sdata), .load_n(load_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT; idx <= '0; ms_cnt <= '0; launched <= 1'b0;
    end else if (rs2) begin
      state <= S_HOLD; idx <= '0; ms_cnt <= '0; launched <= 1'b0;
    end else begin
      case (state)
        S_HOLD: begin
          state  <= S_WAIT;
          ms_cnt <= '0;
        end
        S_WAIT: if (tick) begin
          if (ms_cnt == MSW'(DELAY_MS - 1)) begin
            state <= S_FE;
            idx   <= '0;
          end else begin
            ms_cnt <= ms_cnt + 1'b1;
          end
        end
        S_FE, S_PROG, S_TG, S_EXEC: begin
          if (start) begin
            launched <= 1'b1;
          end else if (launched && frame_done) begin
            launched <= 1'b0;
            case (state)
              S_FE: if (idx == IDX_W'(N_FE - 1)) begin
                state <= S_PROG; idx <= '0;
              end else idx <= idx + 1'b1;
              S_PROG: begin state <= S_TG; idx <= '0; end
              S_TG: if (idx == IDX_W'(N_TG - 1)) begin
                state <= S_EXEC; idx <= '0;
              end else idx <= idx + 1'b1;
              default: state <= S_DONE;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  assign done = (state == S_DONE);

  // R9: a remote request clears the bus one cycle after it is seen
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rs2 |=> (load_n == '1 && !sclk && !done && !tg_rst_n));

  // R8: done is quiet on the bus
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (load_n == '1 && !ser_busy));

  // R8: done follows the execution-mode write
  assert_done_after_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == S_EXEC);

  // R3: front-end strobes only during the front-end phase
  assert_fe_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n[0] || !load_n[1]) |-> state == S_FE);

  // R2: leaving the wait phase only after the full delay count
  assert_delay_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FE && $past(state) == S_WAIT) |-> $past(ms_cnt) == MSW'(DELAY_MS - 1));

endmodule

// File: tb/test_regload_seq.sv
module test_regload_seq;
  import regload_pkg::*;

  localparam int CPM  = 20;
  localparam int DLY  = 3;
  localparam int HALF = 2;
  localparam int NFR  = 9;
  localparam int DMIN = DLY * CPM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       remote_rst = 1'b0;
  logic       tg_rst_n, sclk, sdata, done;
  logic [2:0] load_n;

  always #5 clk = ~clk;

  regload_seq #(.CLKS_PER_MS(CPM), .DELAY_MS(DLY), .SCLK_HALF(HALF)) i_regload_seq (
    .clk(clk), .rst_n(rst_n), .remote_rst(remote_rst), .tg_rst_n(tg_rst_n),
    .sclk(sclk), .sdata(sdata), .load_n(load_n), .done(done)
  );

  int checks = 0, fails = 0;
  int exp_dev [NFR], exp_bits [NFR];
  logic [31:0] exp_raw [NFR];

  // pin monitor
  logic        mon_clr = 1'b0;
  int          cyc = 0, nfr = 0, first_low = -1, bitcnt = 0, last_rise = -1;
  int          overlap = 0, per_bad = 0, stab_bad = 0;
  int          fr_dev [16], fr_bits [16];
  logic [31:0] fr_word [16];
  logic [31:0] acc = 0;
  logic        psclk = 0, psdata = 0;
  logic [2:0]  pload = 3'b111;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      nfr <= 0; first_low <= -1; bitcnt <= 0; acc <= 0; last_rise <= -1;
      overlap <= 0; per_bad <= 0; stab_bad <= 0;
    end else begin
      if (load_n != 3'b111 && first_low < 0) first_low <= cyc;
      if ($countones(~load_n) > 1) overlap <= overlap + 1;
      if (sclk && psclk && sdata != psdata) stab_bad <= stab_bad + 1;
      if (sclk && !psclk) begin
        acc <= {acc[30:0], sdata};
        bitcnt <= bitcnt + 1;
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF) per_bad <= per_bad + 1;
        last_rise <= cyc;
      end
      for (int d = 0; d < 3; d++) begin
        if (load_n[d] && !pload[d] && nfr < 16) begin
          fr_dev[nfr] <= d; fr_bits[nfr] <= bitcnt; fr_word[nfr] <= acc;
          nfr <= nfr + 1; bitcnt <= 0; acc <= 0; last_rise <= -1;
        end
      end
    end
    psclk <= sclk; psdata <= sdata; pload <= load_n;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  task automatic verify_seq(input int rel);
    check(done === 1'b1, "R8 done after sequence", done, 1);
    check(nfr == NFR, "R3 frame count", nfr, NFR);
    check(first_low - rel >= DMIN, "R2 delay lower bound", first_low - rel, DMIN);
    check(first_low - rel <= DMIN + 8, "R2 delay upper bound", first_low - rel, DMIN + 8);
    for (int k = 0; k < NFR; k++) begin
      check(fr_dev[k] == exp_dev[k], "R3 frame device order", fr_dev[k], exp_dev[k]);
      check(fr_bits[k] == exp_bits[k], "R4 frame bit count", fr_bits[k], exp_bits[k]);
      check(fr_word[k] == (exp_raw[k] >> (32 - exp_bits[k])), "R4 frame word MSB first",
            fr_word[k], exp_raw[k] >> (32 - exp_bits[k]));
    end
    check(fr_word[4] == 32'h280, "R7 program-mode wrapper first", fr_word[4], 32'h280);
    check(fr_word[8] == 32'h281, "R7 execution-mode wrapper last", fr_word[8], 32'h281);
    check(overlap == 0, "R6 single strobe", overlap, 0);
    check(per_bad == 0, "R5 sclk period", per_bad, 0);
    check(stab_bad == 0, "R5 data stable while sclk high", stab_bad, 0);
  endtask

  task automatic set_exp(input int k, input int dev, input int nbytes, input int lb, input logic [31:0] w);
    exp_dev[k] = dev; exp_bits[k] = 8 * (nbytes - 1) + lb; exp_raw[k] = w;
  endtask

  bit wd_hit = 0;
  initial begin
    #(190000 * 10);
    wd_hit = 1;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int rel, nsave;
    set_exp(0, 0, 2, 8, 32'h1C30_0000);
    set_exp(1, 0, 2, 8, 32'h2250_0000);
    set_exp(2, 1, 2, 8, 32'h1C30_0000);
    set_exp(3, 1, 2, 8, 32'h2250_0000);
    set_exp(4, 2, 2, 4, 32'h2800_0000);
    set_exp(5, 2, 3, 5, 32'hA5C3_F000);
    set_exp(6, 2, 1, 3, 32'hE000_0000);
    set_exp(7, 2, 4, 8, 32'h1234_5678);
    set_exp(8, 2, 2, 4, 32'h2810_0000);

    mon_clr = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(done === 1'b0, "R1 done in reset", done, 0);
    check(tg_rst_n === 1'b0, "R1 tg_rst_n in reset", tg_rst_n, 0);
    check(sclk === 1'b0, "R1 sclk in reset", sclk, 0);
    check(load_n === 3'b111, "R1 strobes in reset", load_n, 3'b111);
    mon_clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
    wait_done();
    verify_seq(rel);

    // R8 stays done and quiet
    nsave = nfr;
    repeat (300) @(negedge clk);
    check(done === 1'b1 && nfr == nsave, "R8 done holds, no new frame", nfr, nsave);

    // R9 / R10 abort swept across the whole sequence
    for (int k = 0; k < 14; k++) begin
      @(posedge clk); remote_rst = 1'b1;
      repeat (4) @(negedge clk);
      check(tg_rst_n === 1'b0, "R9 tg reset asserted", tg_rst_n, 0);
      check(load_n === 3'b111 && sclk === 1'b0 && done === 1'b0, "R9 bus cleared",
            {done, sclk, load_n}, 5'b00111);
      clear_mon();
      repeat (50) @(negedge clk);
      check(nfr == 0 && first_low < 0, "R9 no frame while held", nfr, 0);
      @(posedge clk); remote_rst = 1'b0;
      rel = cyc;
      if (k == 0) begin
        wait_done();
        verify_seq(rel);
        check(tg_rst_n === 1'b1, "R10 tg reset released", tg_rst_n, 1);
      end else begin
        // interrupt partway: offsets spread over delay and transfers
        repeat (DMIN + k * 53) @(negedge clk);
        if (k == 13) begin
          wait_done();
          verify_seq(rel);
        end
      end
    end
    // final restart after last interruption already verified; one more clean run
    @(posedge clk); remote_rst = 1'b1;
    repeat (6) @(negedge clk);
    clear_mon();
    @(posedge clk); remote_rst = 1'b0;
    rel = cyc;
    wait_done();
    verify_seq(rel);

    if (!wd_hit) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule